// File: doc/BRIEF.md
# Interrupt Request Evaluator

This block decides, every cycle, whether the processor core should take a hardware interrupt. It looks at three control bits of the status word (global enable, exception level, error level), an eight-bit mask field in the status word, an eight-bit pending field in the cause word, a per-thread exemption flag and a debug-mode flag. If any gating condition blocks interrupts, the request is held low. Otherwise the pending and mask fields are combined in one of two ways, chosen by a configuration input.

In line mode, each pending line is masked individually and any surviving line raises the request. In level mode, an external vectoring controller has placed a priority number in the pending field and the mask field is read as a threshold. The request is raised only when the number is strictly above the threshold.

The request is available on a combinational output for same-cycle use. A registered copy is also provided for paths that need a flop boundary. The block has no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `irq_req_eval`

## Requirements
- R1: When status bit 0 (global enable) is 0, `irq_req` is 0.
- R2: When status bit 1 (exception level) is 1, `irq_req` is 0.
- R3: When status bit 2 (error level) is 1, `irq_req` is 0.
- R4: When `thread_exempt` is 1, `irq_req` is 0.
- R5: When `debug_mode` is 1, `irq_req` is 0.
- R6: With no gating active and `ext_ctrl_mode` = 0, `irq_req` is 1 exactly when some bit of cause[15:8] and the status bit at the same position in status[15:8] are both 1.
- R7: With no gating active and `ext_ctrl_mode` = 1, `irq_req` is 1 exactly when cause[15:8], read as an unsigned number, is strictly greater than status[15:8], read as an unsigned number. Equal values give 0.
- R8: In level mode, a pending field of zero never raises `irq_req`, whatever the mask field holds.
- R9: Status bits 31:16 and 7:3, and cause bits 31:16 and 7:0, have no effect on `irq_req`.
- R10: `irq_req_q` takes the value of `irq_req` at each rising clock edge while `rst` is 0. It is 0 after any rising edge at which `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered request |
| rst | input | 1 | Synchronous active-high reset of the registered request |
| status_word | input | 32 | Status register: enable/level bits [2:0], mask field [15:8] |
| cause_word | input | 32 | Cause register: pending field [15:8] |
| thread_exempt | input | 1 | Current thread is exempt from interrupts |
| debug_mode | input | 1 | Core is in debug mode |
| ext_ctrl_mode | input | 1 | 1 = level compare (external controller), 0 = per-line mask |
| irq_req | output | 1 | Combinational interrupt request |
| irq_req_q | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit register width and an eight-line field placed at bit 8. With these defaults, the field edge cases can be reached directly:
- the level values 0x00, 0x7F, 0x80 and 0xFF, which expose an unsigned versus signed mistake;
- equal level values, which expose a greater-or-equal mistake;
- set bits just above and just below the field, which expose a misplaced slice.

Directed vectors drive each gating input on its own against an otherwise requesting state. Seeded random vectors cover both interpretation modes. A reset that arrives mid-run while the combinational request is high checks the registered output.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

  typedef struct packed {
    logic enable;
    logic exc_level;
    logic err_level;
    logic exempt;
    logic debug;
  } irq_gate_t;

endpackage

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
  import irq_eval_pkg::*;
(
  input  irq_gate_t gate,
  output logic      allow
);

  always_comb begin
    allow = gate.enable;
    if (gate.exc_level || gate.err_level) allow = 1'b0;
    if (gate.exempt || gate.debug)        allow = 1'b0;
  end

endmodule

// File: rtl/irq_line_match.sv
module irq_line_match #(
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] pend,
  input  logic [LINE_W-1:0] mask,
  output logic              hit
);

  logic [LINE_W-1:0] live;

  for (genvar i = 0; i < LINE_W; i++) begin : g_line
    assign live[i] = pend[i] & mask[i];
  end

  assign hit = |live;

endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int LINE_W = 8
) (
  input  logic [LINE_W-1:0] level,
  input  logic [LINE_W-1:0] thresh,
  output logic              hit
);

  assign hit = (level > thresh);

endmodule

// File: rtl/irq_req_eval.sv
module irq_req_eval
  import irq_eval_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int LINE_W    = 8,
  parameter int FIELD_LSB = 8,
  parameter int EN_BIT    = 0,
  parameter int EXL_BIT   = 1,
  parameter int ERL_BIT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] status_word,
  input  logic [REG_W-1:0] cause_word,
  input  logic             thread_exempt,
  input  logic             debug_mode,
  input  logic             ext_ctrl_mode,
  output logic             irq_req,
  output logic             irq_req_q
);

  localparam int FIELD_MSB = FIELD_LSB + LINE_W - 1;

  irq_gate_t         gate;
  logic              allow;
  logic [LINE_W-1:0] pend_f;
  logic [LINE_W-1:0] mask_f;
  logic              line_hit;
  logic              lvl_hit;
  logic              unused_parity;

  assign gate.enable    = status_word[EN_BIT];
  assign gate.exc_level = status_word[EXL_BIT];
  assign gate.err_level = status_word[ERL_BIT];
  assign gate.exempt    = thread_exempt;
  assign gate.debug     = debug_mode;

  assign pend_f = cause_word[FIELD_MSB:FIELD_LSB];
  assign mask_f = status_word[FIELD_MSB:FIELD_LSB];
  assign unused_parity = ^{status_word, cause_word};

  irq_gate_ctl u_gate (
    .gate  (gate),
    .allow (allow)
  );

  irq_line_match #(.LINE_W(LINE_W)) u_line (
    .pend (pend_f),
    .mask (mask_f),
    .hit  (line_hit)
  );

  irq_level_cmp #(.LINE_W(LINE_W)) u_lvl (
    .level  (pend_f),
    .thresh (mask_f),
    .hit    (lvl_hit)
  );

  assign irq_req = allow & (ext_ctrl_mode ? lvl_hit : line_hit);

  always_ff @(posedge clk) begin
    if (rst) irq_req_q <= 1'b0;
    else     irq_req_q <= irq_req;
  end

  a_r1_enable_off: assert property (@(posedge clk) disable iff (rst)
    !status_word[EN_BIT] |-> !irq_req);
  a_r2_exc_level: assert property (@(posedge clk) disable iff (rst)
    status_word[EXL_BIT] |-> !irq_req);
  a_r3_err_level: assert property (@(posedge clk) disable iff (rst)
    status_word[ERL_BIT] |-> !irq_req);
  a_r4_exempt: assert property (@(posedge clk) disable iff (rst)
    thread_exempt |-> !irq_req);
  a_r5_debug: assert property (@(posedge clk) disable iff (rst)
    debug_mode |-> !irq_req);
  a_r6_line_source: assert property (@(posedge clk) disable iff (rst)
    (!ext_ctrl_mode && irq_req) |-> ((pend_f & mask_f) != '0));
  a_r7_level_above: assert property (@(posedge clk) disable iff (rst)
    (ext_ctrl_mode && irq_req) |-> (pend_f > mask_f));
  a_r8_zero_level: assert property (@(posedge clk) disable iff (rst)
    (ext_ctrl_mode && pend_f == '0) |-> !irq_req);
  a_r10_reg_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req_q == $past(irq_req)));

endmodule

// File: tb/irq_req_eval_tb.sv
`timescale 1ns/1ps
module irq_req_eval_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] status_word = 32'h0000_0401;
  logic [31:0] cause_word  = 32'h0000_0400;
  logic        thread_exempt = 1'b0;
  logic        debug_mode    = 1'b0;
  logic        ext_ctrl_mode = 1'b0;
  logic        irq_req;
  logic        irq_req_q;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irq_req_eval u_dut (
    .clk           (clk),
    .rst           (rst),
    .status_word   (status_word),
    .cause_word    (cause_word),
    .thread_exempt (thread_exempt),
    .debug_mode    (debug_mode),
    .ext_ctrl_mode (ext_ctrl_mode),
    .irq_req       (irq_req),
    .irq_req_q     (irq_req_q)
  );

  function automatic bit model(logic [31:0] st, logic [31:0] ca,
                               logic ex, logic dbg, logic ext);
    logic [7:0] p;
    logic [7:0] m;
    if (!st[0] || st[1] || st[2] || ex || dbg) return 1'b0;
    p = ca[15:8];
    m = st[15:8];
    if (ext) return (p > m);
    return |(p & m);
  endfunction

  task automatic check(bit got, bit exp, string tag);
    n_cmp++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] st, logic [31:0] ca, logic ex,
                       logic dbg, logic ext, string tag);
    bit e;
    @(negedge clk);
    status_word   = st;
    cause_word    = ca;
    thread_exempt = ex;
    debug_mode    = dbg;
    ext_ctrl_mode = ext;
    e = model(st, ca, ex, dbg, ext);
    #1;
    check(irq_req, e, tag);
    exp_q.push_back(e);
    tag_q.push_back({tag, " registered R10"});
  endtask

  // monitor: registered output against expected items
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(irq_req_q, e, t);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(irq_req_q, 1'b0, "R10 reset state");
    @(negedge clk);
    rst = 1'b0;

    // R6 line mode
    apply(32'h0000_0401, 32'h0000_0400, 0, 0, 0, "R6 single line match");
    apply(32'h0000_0401, 32'h0000_0200, 0, 0, 0, "R6 line unmasked");
    apply(32'h0000_A501, 32'h0000_5A00, 0, 0, 0, "R6 disjoint lines");
    apply(32'h0000_8001, 32'h0000_FF00, 0, 0, 0, "R6 top line");
    apply(32'h0000_0101, 32'h0000_0100, 0, 0, 0, "R6 bottom line");
    apply(32'h0000_FF01, 32'h0000_0000, 0, 0, 0, "R6 nothing pending");
    // gating
    apply(32'h0000_FF00, 32'h0000_FF00, 0, 0, 0, "R1 enable clear");
    apply(32'h0000_FF03, 32'h0000_FF00, 0, 0, 0, "R2 exception level");
    apply(32'h0000_FF05, 32'h0000_FF00, 0, 0, 0, "R3 error level");
    apply(32'h0000_FF01, 32'h0000_FF00, 1, 0, 0, "R4 thread exempt");
    apply(32'h0000_FF01, 32'h0000_FF00, 0, 1, 0, "R5 debug mode");
    apply(32'h0000_0000, 32'h0000_FF00, 0, 0, 1, "R1 enable clear level mode");
    apply(32'h0000_0003, 32'h0000_FF00, 0, 0, 1, "R2 exception level level mode");
    apply(32'h0000_0005, 32'h0000_FF00, 0, 0, 1, "R3 error level level mode");
    apply(32'h0000_0001, 32'h0000_FF00, 1, 0, 1, "R4 exempt level mode");
    apply(32'h0000_0001, 32'h0000_FF00, 0, 1, 1, "R5 debug level mode");
    // R7 level mode
    apply(32'h0000_0501, 32'h0000_0600, 0, 0, 1, "R7 above level");
    apply(32'h0000_0501, 32'h0000_0500, 0, 0, 1, "R7 equal level");
    apply(32'h0000_0501, 32'h0000_0400, 0, 0, 1, "R7 below level");
    apply(32'h0000_7F01, 32'h0000_8000, 0, 0, 1, "R7 unsigned 0x80 over 0x7F");
    apply(32'h0000_FE01, 32'h0000_FF00, 0, 0, 1, "R7 0xFF over 0xFE");
    apply(32'h0000_FF01, 32'h0000_FF00, 0, 0, 1, "R7 0xFF equal");
    apply(32'h0000_0201, 32'h0000_0100, 0, 0, 1, "R7 no line overlap needed");
    // R8
    apply(32'h0000_0001, 32'h0000_0000, 0, 0, 1, "R8 zero over zero");
    apply(32'h0000_8001, 32'h0000_0000, 0, 0, 1, "R8 zero pending");
    // R9
    apply(32'hFFFF_04F9, 32'hFFFF_04FF, 0, 0, 0, "R9 outside bits match");
    apply(32'hFFFF_04F9, 32'hFFFF_03FF, 0, 0, 0, "R9 outside bits no match");
    apply(32'h0000_0001, 32'hFFFF_00FF, 0, 0, 1, "R9 outside bits level");
    apply(32'hFFFF_00F9, 32'h0001_0000, 0, 0, 1, "R9 bit16 ignored level");

    // R10 mid-run reset with request high
    @(negedge clk);
    rst = 1'b1;
    status_word = 32'h0000_0401;
    cause_word  = 32'h0000_0400;
    thread_exempt = 0; debug_mode = 0; ext_ctrl_mode = 0;
    @(posedge clk);
    #1;
    check(irq_req_q, 1'b0, "R10 synchronous reset clears");
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 400; i++) begin
      logic [31:0] st;
      logic [31:0] ca;
      st = $urandom;
      ca = $urandom;
      if (i % 2 == 0) st[2:0] = 3'b001;
      apply(st, ca, ($urandom % 8) == 0, ($urandom % 8) == 0,
            1'($urandom), "R6/R7 random");
    end

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule